// File: doc/BRIEF.md
# Nibble-bus memory read initiator

This block is the host end of a four-bit multiplexed memory bus of the firmware-hub kind. A client hands it one request at a time: a 28-bit byte address and a 4-bit device number. The block then runs one single-byte read on the bus. It marks the start with a one-cycle low frame strobe. It sends the start code, the device number, the address one nibble per cycle and a size code. It then hands the bus to the target over a two-cycle turn-around.

While the target holds the bus, the block reads a sync nibble every cycle. It accepts a bounded run of wait codes and moves on at the ready code. It collects the data byte from the next two nibbles, low half first, and lets the target turn the bus back. It then takes the bus again and pulses done with the byte. A wait run that grows past the bound ends the read with a timeout flag. A sync code that is neither wait nor ready ends it with a protocol flag. The pad itself is not modelled. The block gives a nibble to drive and a separate drive enable, and it reads the incoming nibble on its own input.

Top module: `nbr_read_init`

## Requirements
- R1: During and right after reset the block is idle. frame_n is 1, bus_oe is 1, bus_out is 1111b, req_ready is 1, done, timeout_err and sync_err are 0, and rd_data is 0.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1. In the next cycle (cycle 1 of the read) frame_n is 0 and the block drives 1101b. frame_n is 1 in every other cycle.
- R3: Cycle 2 drives the device number. Cycles 3 to 9 drive the address nibbles with the most significant first: bits 27..24 in cycle 3, down to bits 3..0 in cycle 9.
- R4: Cycle 10 drives the size code 0000b and cycle 11 drives 1111b, both with bus_oe at 1. From cycle 12 bus_oe is 0 until the cycle in which done is pulsed.
- R5: From cycle 13 the block samples one sync nibble per cycle. 0101b means wait, and up to MAX_WAITS wait codes in a row are accepted. 0000b means ready. The nibble sampled in the cycle after ready becomes rd_data bits 3..0, and the nibble after that becomes bits 7..4.
- R6: After the two data nibbles the block leaves the bus to the target for two more cycles. With W wait codes, done is 1 for exactly one cycle, cycle 18+W. In that cycle bus_oe is 1, bus_out is 1111b, req_ready is 1 and rd_data holds the byte.
- R7: When the sampled wait code is number MAX_WAITS+1 in a row, the read stops. In the next cycle done and timeout_err are 1 together, the bus is driven to 1111b again and sync_err is 0.
- R8: When a sync nibble other than 0101b or 0000b is sampled, the read stops. In the next cycle done and sync_err are 1 together, the bus is driven to 1111b again and timeout_err is 0.
- R9: req_ready is 0 from the cycle after a request is taken until the cycle in which done is 1. A request offered while req_ready is 0 is ignored: it changes no nibble of the read in progress and starts no read afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request offered |
| req_addr | input | ADDR_W | Byte address of the request |
| req_id | input | 4 | Device number sent in the select nibble |
| req_ready | output | 1 | High when a request can be taken |
| bus_in | input | 4 | Nibble sampled from the bus |
| bus_out | output | 4 | Nibble driven onto the bus when bus_oe is high |
| bus_oe | output | 1 | Drive enable for bus_out |
| frame_n | output | 1 | Frame strobe, low in the start cycle |
| done | output | 1 | One-cycle pulse when a read ends |
| rd_data | output | 8 | Byte read from the target |
| timeout_err | output | 1 | With done: the wait limit was exceeded |
| sync_err | output | 1 | With done: an unknown sync code arrived |

## Verification
The bench builds the block with MAX_WAITS set to 5, so the full range of accepted wait runs, from none to exactly the limit, is cheap to cover. The timeout path, at limit plus one, then costs only a few extra cycles per read. A target model in the bench answers each read with a chosen wait count, a chosen ending code and a chosen data byte, and checks every cycle of the frame. This covers ready after zero and after the maximum waits, both error endings, and a request offered mid-read.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] NIB_START  = 4'b1101;
    localparam logic [NIB_W-1:0] NIB_SIZE1  = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_ONES   = 4'b1111;
    localparam logic [NIB_W-1:0] SYNC_WAIT  = 4'b0101;
    localparam logic [NIB_W-1:0] SYNC_READY = 4'b0000;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_START,
        PH_SEL,
        PH_ADDR,
        PH_SIZE,
        PH_TAR_DRV,
        PH_TAR_FLT,
        PH_SYNC,
        PH_DATA,
        PH_RTAR_DRV,
        PH_RTAR_FLT
    } phase_e;

    typedef enum logic [1:0] {
        SY_WAIT,
        SY_READY,
        SY_BAD
    } sync_e;

    typedef struct packed {
        logic done;
        logic timeout;
        logic bad_sync;
    } finish_t;

    function automatic sync_e classify_sync(input logic [NIB_W-1:0] nib);
        if (nib == SYNC_WAIT)
            return SY_WAIT;
        else if (nib == SYNC_READY)
            return SY_READY;
        else
            return SY_BAD;
    endfunction

    function automatic logic phase_drives(input phase_e ph);
        return !(ph inside {PH_TAR_FLT, PH_SYNC, PH_DATA, PH_RTAR_DRV, PH_RTAR_FLT});
    endfunction

endpackage

// File: rtl/nbr_wait_ctr.sv
module nbr_wait_ctr #(
    parameter int MAX_WAITS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CNT_W = $clog2(MAX_WAITS + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == CNT_W'(MAX_WAITS));

endmodule

// File: rtl/nbr_seq.sv
module nbr_seq
    import nbr_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int DATA_NIBS = 2,
    parameter int BEAT_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [NIB_W-1:0]  bus_in,
    input  logic              wait_limit,
    output phase_e            phase,
    output logic [BEAT_W-1:0] beat,
    output logic              wait_inc,
    output finish_t           fin
);
    phase_e            phase_d;
    logic [BEAT_W-1:0] beat_d;
    finish_t           fin_d;

    always_comb begin
        phase_d  = phase;
        beat_d   = beat;
        fin_d    = '0;
        wait_inc = 1'b0;
        case (phase)
            PH_IDLE:     if (accept) phase_d = PH_START;
            PH_START:    phase_d = PH_SEL;
            PH_SEL: begin
                phase_d = PH_ADDR;
                beat_d  = '0;
            end
            PH_ADDR: begin
                if (beat == BEAT_W'(ADDR_NIBS - 1))
                    phase_d = PH_SIZE;
                else
                    beat_d = beat + 1'b1;
            end
            PH_SIZE:     phase_d = PH_TAR_DRV;
            PH_TAR_DRV:  phase_d = PH_TAR_FLT;
            PH_TAR_FLT:  phase_d = PH_SYNC;
            PH_SYNC: begin
                case (classify_sync(bus_in))
                    SY_WAIT: begin
                        if (wait_limit) begin
                            phase_d     = PH_IDLE;
                            fin_d.done    = 1'b1;
                            fin_d.timeout = 1'b1;
                        end else begin
                            wait_inc = 1'b1;
                        end
                    end
                    SY_READY: begin
                        phase_d = PH_DATA;
                        beat_d  = '0;
                    end
                    default: begin
                        phase_d        = PH_IDLE;
                        fin_d.done     = 1'b1;
                        fin_d.bad_sync = 1'b1;
                    end
                endcase
            end
            PH_DATA: begin
                if (beat == BEAT_W'(DATA_NIBS - 1))
                    phase_d = PH_RTAR_DRV;
                else
                    beat_d = beat + 1'b1;
            end
            PH_RTAR_DRV: phase_d = PH_RTAR_FLT;
            PH_RTAR_FLT: begin
                phase_d    = PH_IDLE;
                fin_d.done = 1'b1;
            end
            default:     phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            beat  <= '0;
            fin   <= '0;
        end else begin
            phase <= phase_d;
            beat  <= beat_d;
            fin   <= fin_d;
        end
    end

endmodule

// File: rtl/nbr_drive.sv
module nbr_drive
    import nbr_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int ADDR_NIBS = 7,
    parameter int BEAT_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NIB_W-1:0]  req_id,
    input  phase_e            phase,
    input  logic [BEAT_W-1:0] beat,
    output logic [NIB_W-1:0]  bus_out,
    output logic              bus_oe,
    output logic              frame_n
);
    localparam int PAD_W = ADDR_NIBS * NIB_W;

    logic [PAD_W-1:0] addr_q;
    logic [NIB_W-1:0] id_q;
    logic [PAD_W-1:0] addr_shift;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            id_q   <= '0;
        end else if (accept) begin
            addr_q <= PAD_W'(req_addr);
            id_q   <= req_id;
        end
    end

    // most significant nibble goes out at beat 0
    assign addr_shift = addr_q >> (NIB_W * (ADDR_NIBS - 1 - int'(beat)));

    always_comb begin
        case (phase)
            PH_START: bus_out = NIB_START;
            PH_SEL:   bus_out = id_q;
            PH_ADDR:  bus_out = addr_shift[NIB_W-1:0];
            PH_SIZE:  bus_out = NIB_SIZE1;
            default:  bus_out = NIB_ONES;
        endcase
    end

    assign bus_oe  = phase_drives(phase);
    assign frame_n = (phase != PH_START);

endmodule

// File: rtl/nbr_capture.sv
module nbr_capture
    import nbr_pkg::*;
#(
    parameter int DATA_NIBS = 2,
    parameter int BEAT_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       cap_en,
    input  logic [BEAT_W-1:0]          beat,
    input  logic [NIB_W-1:0]           bus_in,
    output logic [DATA_NIBS*NIB_W-1:0] data
);
    // nibble g of the byte arrives at data beat g, low half first
    for (genvar g = 0; g < DATA_NIBS; g++) begin : g_nib
        always_ff @(posedge clk) begin
            if (rst || clr)
                data[g*NIB_W +: NIB_W] <= '0;
            else if (cap_en && (beat == BEAT_W'(g)))
                data[g*NIB_W +: NIB_W] <= bus_in;
        end
    end

endmodule

// File: rtl/nbr_read_init.sv
module nbr_read_init
    import nbr_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int MAX_WAITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_id,
    output logic              req_ready,
    input  logic [3:0]        bus_in,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    output logic              frame_n,
    output logic              done,
    output logic [7:0]        rd_data,
    output logic              timeout_err,
    output logic              sync_err
);
    localparam int ADDR_NIBS = (ADDR_W + NIB_W - 1) / NIB_W;
    localparam int DATA_NIBS = 8 / NIB_W;
    localparam int MAX_BEATS = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
    localparam int BEAT_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

    phase_e            phase;
    logic [BEAT_W-1:0] beat;
    logic              accept;
    logic              wait_inc;
    logic              wait_limit;
    finish_t           fin;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    nbr_seq #(
        .ADDR_NIBS (ADDR_NIBS),
        .DATA_NIBS (DATA_NIBS),
        .BEAT_W    (BEAT_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .bus_in     (bus_in),
        .wait_limit (wait_limit),
        .phase      (phase),
        .beat       (beat),
        .wait_inc   (wait_inc),
        .fin        (fin)
    );

    nbr_wait_ctr #(
        .MAX_WAITS (MAX_WAITS)
    ) wait_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (accept),
        .inc      (wait_inc),
        .at_limit (wait_limit)
    );

    nbr_drive #(
        .ADDR_W    (ADDR_W),
        .ADDR_NIBS (ADDR_NIBS),
        .BEAT_W    (BEAT_W)
    ) drive_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_addr (req_addr),
        .req_id   (req_id),
        .phase    (phase),
        .beat     (beat),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .frame_n  (frame_n)
    );

    nbr_capture #(
        .DATA_NIBS (DATA_NIBS),
        .BEAT_W    (BEAT_W)
    ) cap_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept),
        .cap_en (phase == PH_DATA),
        .beat   (beat),
        .bus_in (bus_in),
        .data   (rd_data)
    );

    assign done        = fin.done;
    assign timeout_err = fin.timeout;
    assign sync_err    = fin.bad_sync;

endmodule

// File: rtl/nbr_read_chk.sv
module nbr_read_chk #(
    parameter int ADDR_W = 28
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_id,
    input logic              req_ready,
    input logic [3:0]        bus_in,
    input logic [3:0]        bus_out,
    input logic              bus_oe,
    input logic              frame_n,
    input logic              done,
    input logic [7:0]        rd_data,
    input logic              timeout_err,
    input logic              sync_err
);

    p_start_follows_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!frame_n && bus_oe && bus_out == 4'b1101));

    p_frame_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
        !frame_n |-> $past(req_valid && req_ready));

    p_select_nibble_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> (bus_oe && bus_out == $past(req_id, 2)));

    p_float_not_framed_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> frame_n);

    p_done_reclaims_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (bus_oe && bus_out == 4'b1111 && req_ready && frame_n));

    p_done_after_float_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(!bus_oe));

    p_timeout_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> (done && !sync_err));

    p_syncerr_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> (done && !timeout_err));

    p_busy_after_take_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_returns_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> done);

endmodule

bind nbr_read_init nbr_read_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_id      (req_id),
    .req_ready   (req_ready),
    .bus_in      (bus_in),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .frame_n     (frame_n),
    .done        (done),
    .rd_data     (rd_data),
    .timeout_err (timeout_err),
    .sync_err    (sync_err)
);

// File: tb/nbr_read_init_tb.sv
module nbr_read_init_tb_top;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 28;
    localparam int MAX_W  = 5;
    localparam int WD_LIM = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_id = '0;
    logic              req_ready;
    logic [3:0]        bus_in = 4'hF;
    logic [3:0]        bus_out;
    logic              bus_oe;
    logic              frame_n;
    logic              done;
    logic [7:0]        rd_data;
    logic              timeout_err;
    logic              sync_err;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    nbr_read_init #(.ADDR_W(ADDR_W), .MAX_WAITS(MAX_W)) dut_i (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_addr (req_addr),
        .req_id (req_id), .req_ready (req_ready), .bus_in (bus_in),
        .bus_out (bus_out), .bus_oe (bus_oe), .frame_n (frame_n),
        .done (done), .rd_data (rd_data), .timeout_err (timeout_err),
        .sync_err (sync_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_drive(input int k, input logic [ADDR_W-1:0] a,
                                             input logic [3:0] id);
        if (k == 1) return 4'b1101;
        if (k == 2) return id;
        if (k >= 3 && k <= 9) return a[(9 - k)*4 +: 4];
        if (k == 10) return 4'b0000;
        return 4'b1111;
    endfunction

    function automatic string req_of(input int k);
        if (k <= 1) return "R2";
        if (k <= 9) return "R3";
        return "R4";
    endfunction

    // mode: 0 normal, 1 timeout, 2 bad sync at index bad_at
    task automatic run_read(input logic [ADDR_W-1:0] a, input logic [3:0] id,
                            input int waits, input int mode, input int bad_at,
                            input logic [3:0] bad_val, input logic [7:0] dbyte,
                            input bit poke);
        int done_k;
        int s;
        logic [3:0] ex;
        bit exp_oe;
        if (mode == 0)      done_k = 18 + waits;
        else if (mode == 1) done_k = 14 + MAX_W;
        else                done_k = 14 + bad_at;
        req_valid = 1'b1;
        req_addr  = a;
        req_id    = id;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        req_id    = ~id;
        for (int k = 1; k <= done_k; k++) begin
            exp_oe = (k <= 11) || (k == done_k);
            chk(frame_n == (k != 1), "R2", $sformatf("frame_n cycle %0d", k), 32'(frame_n), 32'(k != 1));
            chk(bus_oe == exp_oe, (k == done_k) ? "R6" : "R4", $sformatf("bus_oe cycle %0d", k), 32'(bus_oe), 32'(exp_oe));
            if (exp_oe) begin
                ex = exp_drive(k, a, id);
                chk(bus_out == ex, (k == done_k) ? "R6" : req_of(k), $sformatf("bus_out cycle %0d", k), 32'(bus_out), 32'(ex));
            end
            chk(done == (k == done_k), "R6", $sformatf("done cycle %0d", k), 32'(done), 32'(k == done_k));
            chk(req_ready == (k == done_k), "R9", $sformatf("req_ready cycle %0d", k), 32'(req_ready), 32'(k == done_k));
            if (k == done_k) begin
                if (mode == 0)
                    chk(rd_data == dbyte, "R5", "rd_data", 32'(rd_data), 32'(dbyte));
                chk(timeout_err == (mode == 1), "R7", "timeout_err", 32'(timeout_err), 32'(mode == 1));
                chk(sync_err == (mode == 2), "R8", "sync_err", 32'(sync_err), 32'(mode == 2));
            end
            // target model: value for this cycle
            s = k - 13;
            if (s < 0)                          bus_in = 4'hF;
            else if (mode == 1)                 bus_in = 4'b0101;
            else if (mode == 2)                 bus_in = (s == bad_at) ? bad_val : 4'b0101;
            else if (s < waits)                 bus_in = 4'b0101;
            else if (s == waits)                bus_in = 4'b0000;
            else if (s == waits + 1)            bus_in = dbyte[3:0];
            else if (s == waits + 2)            bus_in = dbyte[7:4];
            else                                bus_in = 4'hF;
            if (poke && k == 2) begin
                req_valid = 1'b1;
                req_addr  = ~a;
                req_id    = ~id;
            end
            if (poke && k == 5) req_valid = 1'b0;
            @(negedge clk);
        end
        bus_in = 4'hF;
        for (int j = 0; j < 3; j++) begin
            chk(frame_n && req_ready && !done, "R9", $sformatf("idle after read %0d", j),
                32'({frame_n, req_ready, done}), 32'(3'b110));
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(frame_n && bus_oe && bus_out == 4'hF && req_ready && !done, "R1", "in reset",
            32'({frame_n, bus_oe, bus_out, req_ready, done}), 32'(8'b11111110));
        rst = 1'b0;
        @(negedge clk);
        chk(frame_n && bus_oe && bus_out == 4'hF && req_ready && !done && !timeout_err
            && !sync_err && rd_data == 8'h00, "R1", "after reset",
            32'({frame_n, bus_oe, bus_out, req_ready, done, timeout_err, sync_err, rd_data}),
            32'(18'b11_1111_1000_0000_0000));

        run_read(28'h1234567, 4'h3, 0, 0, 0, 4'h0, 8'hA5, 1'b0);       // R5 no waits
        run_read(28'hFEDCBA9, 4'hC, MAX_W, 0, 0, 4'h0, 8'h3C, 1'b0);   // R5 wait at limit
        run_read(28'h0F0F0F0, 4'h7, 0, 1, 0, 4'h0, 8'h00, 1'b0);       // R7 timeout
        run_read(28'h0000001, 4'h0, 0, 2, 0, 4'b1010, 8'h00, 1'b0);    // R8 bad first sync
        run_read(28'h8000000, 4'hF, 0, 2, 3, 4'b0011, 8'h00, 1'b0);    // R8 bad after waits
        run_read(28'h2468ACE, 4'h5, 2, 0, 0, 4'h0, 8'h96, 1'b1);       // R9 poke while busy

        for (int n = 0; n < 40; n++) begin
            logic [ADDR_W-1:0] ra;
            logic [3:0] ri;
            int rw;
            logic [7:0] rb;
            ra = ADDR_W'($urandom);
            ri = 4'($urandom);
            rw = int'($urandom % (MAX_W + 1));
            rb = 8'($urandom);
            run_read(ra, ri, rw, 0, 0, 4'h0, rb, n[0]);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_LIM && !finished) begin
                finished = 1'b1;
                total++;
                bad++;
                $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WD_LIM);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

endmodule